// File: doc/BRIEF.md
# Ethernet PAUSE Flow Controller

This block supplies both halves of full-duplex flow control for a 10 Mb/s MAC. The receive side watches how many bytes remain free in the receive ring. When space runs short it asks the frame builder to send a PAUSE frame that stops the far station. Once that frame has gone out and the host has moved its read boundary forward, it asks for a second PAUSE frame with a zero time, which lets the far station transmit again.

The transmit side takes strobes from the frame parser for each valid PAUSE frame received, together with its 16-bit time field. It then holds back ordinary data frames for that many quanta of 51.2 µs. The quantum is derived from the system clock by a prescaler. A frame already in progress is never cut short: a PAUSE that arrives while the transmitter is busy is held and applied only when that frame ends. MAC control frames are always allowed to start. In half-duplex operation the block raises no requests and applies no hold.

Top module: `pause_flow_ctrl`

## Requirements
- R1: After reset, `pause_req` and `tx_hold` are 0.
- R2: With `full_duplex` high and no request outstanding, `rx_free_bytes` below XOFF_LIMIT (default 3072) raises `pause_req` with `pause_val` = 16'hFFFF on the next cycle. A value equal to XOFF_LIMIT raises no request.
- R3: While `pause_req` is high, it stays high and `pause_val` stays unchanged until `pause_ack` is seen. The cycle after `pause_ack`, `pause_req` is low.
- R4: After an XOFF has been acknowledged, a `bnry_upd` strobe raises `pause_req` with `pause_val` = 16'h0000 on the next cycle. A `bnry_upd` that arrives before the XOFF is acknowledged is ignored.
- R5: Only one XOFF is outstanding at a time. After an acknowledged XOFF, no new request appears until a boundary update. Once the XON is acknowledged, low free space can raise a new XOFF.
- R6: A `pause_rx_vld` strobe with a nonzero `pause_rx_time` n, received while `tx_busy` is low, sets `tx_hold` from the next cycle for exactly n × CYC_PER_QUANTUM cycles.
- R7: A nonzero PAUSE received while `tx_busy` is high leaves `tx_hold` low for as long as `tx_busy` stays high. The hold then starts the cycle after `tx_busy` falls and lasts the full n quanta.
- R8: A received PAUSE with time 0 clears `tx_hold` on the next cycle. It also discards a PAUSE still waiting for the current frame to end.
- R9: A nonzero PAUSE received during an active hold reloads the timer. The hold then lasts n quanta from the reload, with a fresh quantum phase.
- R10: `tx_start_ok` equals `tx_start_req` when `tx_ctrl` is 1 (control frame) or `tx_hold` is 0. Otherwise it is 0.
- R11: With `full_duplex` low, `pause_req` and `tx_hold` are 0 from the next cycle. Free-space, boundary and PAUSE inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| full_duplex | input | 1 | Enables flow control when 1 |
| rx_free_bytes | input | FREE_W | Free bytes in the receive ring |
| bnry_upd | input | 1 | Host advanced its read boundary (one-cycle strobe) |
| pause_rx_vld | input | 1 | Valid PAUSE frame received (one-cycle strobe) |
| pause_rx_time | input | 16 | Time field of the received PAUSE, in quanta |
| tx_busy | input | 1 | A frame is being transmitted |
| tx_start_req | input | 1 | Transmitter wants to start a frame |
| tx_ctrl | input | 1 | The frame to start is a MAC control frame |
| tx_start_ok | output | 1 | Start of the requested frame is permitted |
| tx_hold | output | 1 | Data transmission is paused |
| pause_req | output | 1 | Request to send a PAUSE frame |
| pause_val | output | 16 | Time value for the requested PAUSE frame |
| pause_ack | input | 1 | Requested PAUSE frame has been sent |

## Verification
The bench builds the block with CYC_PER_QUANTUM = 4, so a pause of a few quanta lasts only a handful of cycles. The exact hold length, the deferral until the busy frame ends, the reload and the zero-time cancel can all be counted cycle by cycle. XOFF_LIMIT keeps its default of 3072 and FREE_W is 16, so the free-space comparison is exercised exactly at 3071 and 3072.

// File: rtl/pause_fc_pkg.sv
package pause_fc_pkg;
  localparam int PT_W = 16;
  localparam logic [PT_W-1:0] STOP_TIME = 16'hFFFF;
  localparam logic [PT_W-1:0] GO_TIME   = 16'h0000;

  typedef enum logic [1:0] {
    FC_IDLE      = 2'd0,
    FC_XOFF_WAIT = 2'd1,
    FC_XOFF_SENT = 2'd2,
    FC_XON_WAIT  = 2'd3
  } fc_state_e;
endpackage

// File: rtl/quanta_tick.sv
module quanta_tick #(
  parameter int CYC_PER_QUANTUM = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CNT_W = (CYC_PER_QUANTUM > 2) ? $clog2(CYC_PER_QUANTUM) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_PER_QUANTUM - 1);

  logic [CNT_W-1:0] pcnt_q;

  assign tick = (pcnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) pcnt_q <= '0;
    else if (tick)      pcnt_q <= '0;
    else                pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/xoff_xon_gen.sv
module xoff_xon_gen
  import pause_fc_pkg::*;
#(
  parameter int FREE_W      = 16,
  parameter int XOFF_LIMIT  = 3072
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              full_duplex,
  input  logic [FREE_W-1:0] rx_free_bytes,
  input  logic              bnry_upd,
  input  logic              pause_ack,
  output logic              pause_req,
  output logic [PT_W-1:0]   pause_val
);
  localparam logic [FREE_W-1:0] LIMIT = FREE_W'(XOFF_LIMIT);

  fc_state_e state_q;
  logic      low_space;

  assign low_space = (rx_free_bytes < LIMIT);

  always_ff @(posedge clk) begin
    if (rst || !full_duplex) begin
      state_q   <= FC_IDLE;
      pause_req <= 1'b0;
      pause_val <= GO_TIME;
    end else begin
      case (state_q)
        FC_IDLE: if (low_space) begin
          state_q   <= FC_XOFF_WAIT;
          pause_req <= 1'b1;
          pause_val <= STOP_TIME;
        end
        FC_XOFF_WAIT: if (pause_ack) begin
          state_q   <= FC_XOFF_SENT;
          pause_req <= 1'b0;
        end
        FC_XOFF_SENT: if (bnry_upd) begin
          state_q   <= FC_XON_WAIT;
          pause_req <= 1'b1;
          pause_val <= GO_TIME;
        end
        FC_XON_WAIT: if (pause_ack) begin
          state_q   <= FC_IDLE;
          pause_req <= 1'b0;
        end
        default: state_q <= FC_IDLE;
      endcase
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pause_req && !pause_ack && full_duplex) |=> (pause_req && $stable(pause_val)));
  // R3
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (pause_req && pause_ack) |=> !pause_req);
  // R11
  hd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !full_duplex |=> !pause_req);
endmodule

// File: rtl/pause_hold.sv
module pause_hold
  import pause_fc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            full_duplex,
  input  logic            tick,
  input  logic            rx_vld,
  input  logic [PT_W-1:0] rx_time,
  input  logic            tx_busy,
  output logic            restart,
  output logic            active_q
);
  logic            pend_q;
  logic [PT_W-1:0] pend_time_q;
  logic [PT_W-1:0] cnt_q;
  logic            zero_rx;
  logic            load;
  logic [PT_W-1:0] load_val;

  assign zero_rx = rx_vld && (rx_time == GO_TIME);

  always_comb begin
    load     = 1'b0;
    load_val = rx_time;
    if (!tx_busy) begin
      if (rx_vld && !zero_rx) begin
        load     = 1'b1;
        load_val = rx_time;
      end else if (pend_q && !rx_vld) begin
        load     = 1'b1;
        load_val = pend_time_q;
      end
    end
  end

  assign restart = load;

  always_ff @(posedge clk) begin
    if (rst || !full_duplex) begin
      active_q    <= 1'b0;
      pend_q      <= 1'b0;
      pend_time_q <= '0;
      cnt_q       <= '0;
    end else begin
      if (active_q && tick) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == 16'd1) active_q <= 1'b0;
      end
      if (zero_rx) begin
        active_q <= 1'b0;
        pend_q   <= 1'b0;
      end else if (rx_vld && tx_busy) begin
        pend_q      <= 1'b1;
        pend_time_q <= rx_time;
      end else if (load) begin
        active_q <= 1'b1;
        cnt_q    <= load_val;
        pend_q   <= 1'b0;
      end
    end
  end

  // R11
  hd_nohold_chk: assert property (@(posedge clk) disable iff (rst)
    !full_duplex |=> !active_q);
  // R8
  zero_end_chk: assert property (@(posedge clk) disable iff (rst)
    zero_rx |=> !active_q);
  // R6
  no_early_end_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q && !tick && !rx_vld && full_duplex) |=> active_q);
  // R7
  defer_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_vld && tx_busy && !active_q) |=> !active_q);
endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl
  import pause_fc_pkg::*;
#(
  parameter int FREE_W          = 16,
  parameter int XOFF_LIMIT      = 3072,
  parameter int CYC_PER_QUANTUM = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              full_duplex,
  input  logic [FREE_W-1:0] rx_free_bytes,
  input  logic              bnry_upd,
  input  logic              pause_rx_vld,
  input  logic [15:0]       pause_rx_time,
  input  logic              tx_busy,
  input  logic              tx_start_req,
  input  logic              tx_ctrl,
  output logic              tx_start_ok,
  output logic              tx_hold,
  output logic              pause_req,
  output logic [15:0]       pause_val,
  input  logic              pause_ack
);
  logic tick;
  logic restart;

  xoff_xon_gen #(.FREE_W(FREE_W), .XOFF_LIMIT(XOFF_LIMIT)) u_gen (
    .clk(clk), .rst(rst), .full_duplex(full_duplex),
    .rx_free_bytes(rx_free_bytes), .bnry_upd(bnry_upd),
    .pause_ack(pause_ack), .pause_req(pause_req), .pause_val(pause_val)
  );

  quanta_tick #(.CYC_PER_QUANTUM(CYC_PER_QUANTUM)) u_tick (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick)
  );

  pause_hold u_hold (
    .clk(clk), .rst(rst), .full_duplex(full_duplex), .tick(tick),
    .rx_vld(pause_rx_vld), .rx_time(pause_rx_time), .tx_busy(tx_busy),
    .restart(restart), .active_q(tx_hold)
  );

  assign tx_start_ok = tx_start_req && (tx_ctrl || !tx_hold);
endmodule

// File: tb/tb_pause_flow_ctrl.sv
module tb_pause_flow_ctrl;
  localparam int Q  = 4;
  localparam int FW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic full_duplex = 1'b1;
  logic [FW-1:0] rx_free_bytes = 16'hFFFF;
  logic bnry_upd = 1'b0;
  logic pause_rx_vld = 1'b0;
  logic [15:0] pause_rx_time = 16'd0;
  logic tx_busy = 1'b0;
  logic tx_start_req = 1'b0;
  logic tx_ctrl = 1'b0;
  logic pause_ack = 1'b0;
  logic tx_start_ok, tx_hold, pause_req;
  logic [15:0] pause_val;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pause_flow_ctrl #(.FREE_W(FW), .XOFF_LIMIT(3072), .CYC_PER_QUANTUM(Q)) dut (
    .clk(clk), .rst(rst), .full_duplex(full_duplex), .rx_free_bytes(rx_free_bytes),
    .bnry_upd(bnry_upd), .pause_rx_vld(pause_rx_vld), .pause_rx_time(pause_rx_time),
    .tx_busy(tx_busy), .tx_start_req(tx_start_req), .tx_ctrl(tx_ctrl),
    .tx_start_ok(tx_start_ok), .tx_hold(tx_hold), .pause_req(pause_req),
    .pause_val(pause_val), .pause_ack(pause_ack)
  );

  // {pause time, busy cycles before release}
  localparam logic [31:0] VEC [5] = '{
    {16'd1, 16'd0}, {16'd2, 16'd0}, {16'd5, 16'd0}, {16'd3, 16'd3}, {16'd4, 16'd1}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_pause(input logic [15:0] t);
    pause_rx_time = t;
    pause_rx_vld  = 1'b1;
    step();
    pause_rx_vld  = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (tx_hold && n < 5000) begin
      n++;
      step();
    end
  endtask

  task automatic strobe_ack();
    pause_ack = 1'b1;
    step();
    pause_ack = 1'b0;
  endtask

  task automatic strobe_bnry();
    bnry_upd = 1'b1;
    step();
    bnry_upd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    step(); step(); step();
    chk("R1 req in reset", pause_req, 0);
    chk("R1 hold in reset", tx_hold, 0);
    rst = 1'b0;
    step();
    chk("R1 req after reset", pause_req, 0);

    // R6 R7 table walk
    foreach (VEC[i]) begin
      logic [15:0] t;
      int busy_len;
      t = VEC[i][31:16];
      busy_len = int'(VEC[i][15:0]);
      if (busy_len > 0) begin
        tx_busy = 1'b1;
        pulse_pause(t);
        chk("R7 deferred while busy", tx_hold, 0);
        for (int k = 1; k < busy_len; k++) begin
          step();
          chk("R7 still deferred", tx_hold, 0);
        end
        tx_busy = 1'b0;
        step();
      end else begin
        pulse_pause(t);
      end
      measure(n);
      chk(busy_len > 0 ? "R7 hold length" : "R6 hold length", n, int'(t) * Q);
      step();
    end

    // R8 zero time ends hold
    pulse_pause(16'd10);
    step(); step();
    chk("R8 hold before zero", tx_hold, 1);
    pulse_pause(16'd0);
    chk("R8 hold cleared by zero", tx_hold, 0);
    // R8 zero cancels a deferred pause
    tx_busy = 1'b1;
    pulse_pause(16'd5);
    pulse_pause(16'd0);
    tx_busy = 1'b0;
    step(); step();
    chk("R8 deferred pause discarded", tx_hold, 0);

    // R9 reload during hold
    pulse_pause(16'd2);
    repeat (4) step();
    chk("R9 hold before reload", tx_hold, 1);
    pulse_pause(16'd3);
    measure(n);
    chk("R9 reloaded length", n, 3 * Q);

    // R10 start gating
    tx_start_req = 1'b1;
    tx_ctrl = 1'b0;
    #1;
    chk("R10 data start while idle", tx_start_ok, 1);
    pulse_pause(16'd3);
    chk("R10 data start blocked", tx_start_ok, 0);
    tx_ctrl = 1'b1;
    #1;
    chk("R10 control start allowed", tx_start_ok, 1);
    tx_start_req = 1'b0;
    #1;
    chk("R10 no request no start", tx_start_ok, 0);
    tx_ctrl = 1'b0;
    pulse_pause(16'd0);

    // R2 threshold boundary
    rx_free_bytes = 16'd3072;
    step(); step();
    chk("R2 no xoff at limit", pause_req, 0);
    rx_free_bytes = 16'd3071;
    step();
    chk("R2 xoff request", pause_req, 1);
    chk("R2 xoff value", pause_val, 16'hFFFF);
    // R4 early boundary ignored
    strobe_bnry();
    chk("R4 early bnry ignored req", pause_req, 1);
    chk("R4 early bnry ignored val", pause_val, 16'hFFFF);
    // R3 hold until ack
    step(); step();
    chk("R3 req held", pause_req, 1);
    strobe_ack();
    chk("R3 req dropped after ack", pause_req, 0);
    // R5 no second xoff
    repeat (3) step();
    chk("R5 single xoff", pause_req, 0);
    // R4 xon
    strobe_bnry();
    chk("R4 xon request", pause_req, 1);
    chk("R4 xon value", pause_val, 16'h0000);
    strobe_ack();
    chk("R3 xon dropped after ack", pause_req, 0);
    step();
    chk("R5 rearmed xoff", pause_req, 1);
    chk("R5 rearmed value", pause_val, 16'hFFFF);
    rx_free_bytes = 16'hFFFF;
    strobe_ack();
    strobe_bnry();
    strobe_ack();
    step();
    chk("R2 idle with space", pause_req, 0);

    // R11 half duplex
    pulse_pause(16'd5);
    chk("R11 hold before disable", tx_hold, 1);
    full_duplex = 1'b0;
    step();
    chk("R11 hold cleared", tx_hold, 0);
    pulse_pause(16'd5);
    step();
    chk("R11 pause ignored", tx_hold, 0);
    rx_free_bytes = 16'd100;
    step(); step();
    chk("R11 no request", pause_req, 0);
    full_duplex = 1'b1;
    step();
    chk("R11 request after enable", pause_req, 1);
    full_duplex = 1'b0;
    step();
    chk("R11 request cleared", pause_req, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule